// File: doc/BRIEF.md
# Thirty-Two Source Interrupt Controller Core

This block gathers up to thirty-two interrupt request lines into two processor-facing outputs: a normal request and a critical request. Each source has a bit in a status register. A per-source trigger-type bit decides how that bit is captured. A per-source routing bit sends the source to either the normal output or the critical output. An enable register gates which latched sources may reach either output.

Software programs the block through a simple register bus made of an address, a write strobe, write data and a combinational read-data return. It sees the following registers:

- status, with write-one-to-clear semantics;
- a write-one-to-set alias of status;
- enable;
- critical routing;
- a stored-only polarity word;
- trigger type;
- a read-only view of status ANDed with enable.

Vector generation is handled outside this block. Its two register slots read as zero here.

Top module: `intc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the status, enable, critical-routing, polarity and trigger-type registers clear to zero, and both outputs are low after the next edge.
- R2: Input `srcIn[n]` drives status bit `NUM_SRC-1-n`, so source 0 lands in bit 31 and source 31 lands in bit 0.
- R3: When a source's trigger-type bit is 1 (edge mode), a 0-to-1 transition of its input sets its status bit. A falling input leaves the bit unchanged. An input that is held high does not set the bit again after it has been cleared.
- R4: When a source's trigger-type bit is 0 (level mode), a rising input sets its status bit and a falling input clears it.
- R5: A write to offset 0 clears every status bit written as 1. In the same update, each level-mode source whose input is high leaves its bit set.
- R6: A write to offset 1 ORs the write data into status. A read of offset 0 or offset 1 returns status.
- R7: `normIrq` is high exactly when status AND enable AND NOT critical-routing was non-zero at the previous clock edge. This gives a one-cycle lag after any register update.
- R8: `critIrq` is high exactly when status AND enable AND critical-routing was non-zero at the previous clock edge.
- R9: A read of offset 6 returns status AND enable. Writes to offset 6 change nothing.
- R10: Offsets 2, 3, 4 and 5 are enable, critical routing, polarity and trigger type, each read back as written. The polarity word never affects status or outputs.
- R11: An address is the default base 0x30 plus the offset. Offsets 7 and 8, and every other address outside offsets 0 to 6, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| srcIn | input | NUM_SRC | Interrupt request lines, active high |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write strobe, sampled at the clock edge |
| busWrData | input | NUM_SRC | Write data |
| busRdData | output | NUM_SRC | Combinational read data for `busAddr` |
| normIrq | output | 1 | Registered normal interrupt request |
| critIrq | output | 1 | Registered critical interrupt request |

## Verification
The capture path is driven with level-mode sources held high across a clear, which separates the re-set rule from a plain write-one-to-clear. Edge-mode sources are given a fall, a held level and a fresh rise, which separates true transition capture from level capture. Routing is exercised by moving one active source between the enable and critical masks, so the normal and critical outputs must split rather than mirror each other. Writes aimed at the masked view, the vector slots and addresses outside the window are each followed by readbacks of status and enable, which exposes any stray decode.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int OFF_STATUS = 0;
  localparam int OFF_SET    = 1;
  localparam int OFF_ENABLE = 2;
  localparam int OFF_CRIT   = 3;
  localparam int OFF_POL    = 4;
  localparam int OFF_TRIG   = 5;
  localparam int OFF_MASKED = 6;

  // Write strobes passed from bus decode to the register datapath.
  typedef struct packed {
    logic wrStatus;
    logic wrSet;
    logic wrEnable;
    logic wrCrit;
    logic wrPol;
    logic wrTrig;
  } wrStrobes_t;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int NUM_SRC = 32,
  parameter int BASE    = 'h30
) (
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] statusQ,
  input  logic [NUM_SRC-1:0] enableQ,
  input  logic [NUM_SRC-1:0] critQ,
  input  logic [NUM_SRC-1:0] polQ,
  input  logic [NUM_SRC-1:0] trigQ,
  output wrStrobes_t         strb,
  output logic [NUM_SRC-1:0] busRdData
);

  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(BASE + OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(BASE + OFF_SET);
  localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(BASE + OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_CRT = ADDR_W'(BASE + OFF_CRIT);
  localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(BASE + OFF_POL);
  localparam logic [ADDR_W-1:0] A_TRG = ADDR_W'(BASE + OFF_TRIG);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(BASE + OFF_MASKED);

  always_comb begin
    strb = '0;
    if (busWrEn) begin
      case (busAddr)
        A_STS:   strb.wrStatus = 1'b1;
        A_SET:   strb.wrSet    = 1'b1;
        A_ENA:   strb.wrEnable = 1'b1;
        A_CRT:   strb.wrCrit   = 1'b1;
        A_POL:   strb.wrPol    = 1'b1;
        A_TRG:   strb.wrTrig   = 1'b1;
        default: strb = '0;
      endcase
    end
  end

  always_comb begin
    case (busAddr)
      A_STS, A_SET: busRdData = statusQ;
      A_ENA:        busRdData = enableQ;
      A_CRT:        busRdData = critQ;
      A_POL:        busRdData = polQ;
      A_TRG:        busRdData = trigQ;
      A_MSK:        busRdData = statusQ & enableQ;
      default:      busRdData = '0;
    endcase
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [NUM_SRC-1:0] busWrData,
  input  wrStrobes_t         strb,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [NUM_SRC-1:0] critQ,
  output logic [NUM_SRC-1:0] polQ,
  output logic [NUM_SRC-1:0] trigQ,
  output logic               normIrq,
  output logic               critIrq
);

  logic [NUM_SRC-1:0] mappedIn;
  logic [NUM_SRC-1:0] prevIn;
  logic [NUM_SRC-1:0] riseV;
  logic [NUM_SRC-1:0] fallV;
  logic [NUM_SRC-1:0] statusD;

  // Source n drives status bit NUM_SRC-1-n.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
    assign mappedIn[NUM_SRC-1-n] = srcIn[n];
  end

  assign riseV = mappedIn & ~prevIn;
  assign fallV = ~mappedIn & prevIn;

  always_comb begin
    statusD = statusQ;
    if (strb.wrStatus) statusD = (statusD & ~busWrData) | (mappedIn & ~trigQ);
    if (strb.wrSet)    statusD = statusD | busWrData;
    statusD = statusD | riseV;            // rising input sets in both modes
    statusD = statusD & ~(fallV & ~trigQ); // level sources follow a fall
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
      enableQ <= '0;
      critQ   <= '0;
      polQ    <= '0;
      trigQ   <= '0;
      prevIn  <= '0;
      normIrq <= 1'b0;
      critIrq <= 1'b0;
    end else begin
      statusQ <= statusD;
      prevIn  <= mappedIn;
      if (strb.wrEnable) enableQ <= busWrData;
      if (strb.wrCrit)   critQ   <= busWrData;
      if (strb.wrPol)    polQ    <= busWrData;
      if (strb.wrTrig)   trigQ   <= busWrData;
      normIrq <= |(statusQ & enableQ & ~critQ);
      critIrq <= |(statusQ & enableQ & critQ);
    end
  end

endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 10,
  parameter int BASE    = 'h30
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  output logic               normIrq,
  output logic               critIrq
);

  wrStrobes_t         strb;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] critQ;
  logic [NUM_SRC-1:0] polQ;
  logic [NUM_SRC-1:0] trigQ;

  intc_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .BASE(BASE)) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn),
    .statusQ(statusQ), .enableQ(enableQ), .critQ(critQ),
    .polQ(polQ), .trigQ(trigQ),
    .strb(strb), .busRdData(busRdData)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk), .rst(rst), .srcIn(srcIn), .busWrData(busWrData), .strb(strb),
    .statusQ(statusQ), .enableQ(enableQ), .critQ(critQ),
    .polQ(polQ), .trigQ(trigQ),
    .normIrq(normIrq), .critIrq(critIrq)
  );

endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 10,
  parameter int BASE    = 'h30
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [NUM_SRC-1:0] busRdData,
  input logic               wrStatus,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic [NUM_SRC-1:0] critQ,
  input logic [NUM_SRC-1:0] trigQ,
  input logic               normIrq,
  input logic               critIrq
);

  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(BASE + 6);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (statusQ == '0 && enableQ == '0 && critQ == '0 && trigQ == '0));

  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !wrStatus |=> ((($past(statusQ) & $past(trigQ)) & ~statusQ) == '0));

  assert_norm_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (|(statusQ & enableQ & ~critQ)) |=> normIrq);

  assert_norm_drop_R7: assert property (@(posedge clk) disable iff (rst)
    !(|(statusQ & enableQ & ~critQ)) |=> !normIrq);

  assert_crit_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (|(statusQ & enableQ & critQ)) |=> critIrq);

  assert_crit_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !(|(statusQ & enableQ & critQ)) |=> !critIrq);

  assert_masked_view_R9: assert property (@(posedge clk) disable iff (rst)
    (busAddr == A_MSK) |-> (busRdData == (statusQ & enableQ)));

endmodule

bind intc_core intc_core_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busRdData(busRdData),
  .wrStatus(strb.wrStatus), .statusQ(statusQ), .enableQ(enableQ),
  .critQ(critQ), .trigQ(trigQ), .normIrq(normIrq), .critIrq(critIrq)
);

// File: tb/test_intc_core.sv
module test_intc_core;

  localparam int PERIOD = 10;
  localparam int BASE   = 'h30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] srcIn = '0;
  logic [9:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        normIrq;
  logic        critIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;   // 0 read data, 1 normal out, 2 critical out
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #(PERIOD/2) clk = ~clk;

  intc_core i_intc_core (
    .clk(clk), .rst(rst), .srcIn(srcIn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .normIrq(normIrq), .critIrq(critIrq)
  );

  // Monitor: pop one expectation per cycle, a quarter period after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (expQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.kind)
          0:       act = busRdData;
          1:       act = {31'b0, normIrq};
          default: act = {31'b0, critIrq};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input int off, input logic [31:0] d);
    @(negedge clk);
    busAddr = 10'(BASE + off);
    busWrData = d;
    busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic wrAbs(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    busWrData = d;
    busWrEn = 1'b1;
    @(posedge clk);
    #1 busWrEn = 1'b0;
  endtask

  task automatic rdAbs(input logic [9:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busAddr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic rd(input int off, input logic [31:0] e, input string tag);
    rdAbs(10'(BASE + off), e, tag);
  endtask

  task automatic expectOut(input int kind, input logic v, input string tag);
    item_t it;
    repeat (2) @(negedge clk);
    it.kind = kind; it.exp = {31'b0, v}; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic setSrc(input int n, input logic v);
    @(negedge clk);
    srcIn[n] = v;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expectOut(1, 1'b0, "R1 normIrq after reset");
    expectOut(2, 1'b0, "R1 critIrq after reset");
    rd(0, 32'h0, "R1 status after reset");
    rd(2, 32'h0, "R1 enable after reset");
    rd(5, 32'h0, "R1 trigger after reset");
    // R2/R4 level source 0 -> bit 31
    wr(2, 32'hFFFF_FFFF);
    setSrc(0, 1'b1);
    rd(0, 32'h8000_0000, "R2 R4 source 0 sets bit 31");
    expectOut(1, 1'b1, "R7 normal raised by level source");
    expectOut(2, 1'b0, "R8 critical stays low");
    // R5 clear while level input held
    wr(0, 32'h8000_0000);
    rd(0, 32'h8000_0000, "R5 level bit re-set on clear");
    setSrc(0, 1'b0);
    rd(0, 32'h0, "R4 level falls clears");
    expectOut(1, 1'b0, "R7 normal drops");
    // R3 edge source 31 -> bit 0
    wr(5, 32'h0000_0001);
    rd(5, 32'h0000_0001, "R10 trigger readback");
    setSrc(31, 1'b1);
    rd(0, 32'h0000_0001, "R3 rising edge sets bit 0");
    setSrc(31, 1'b0);
    rd(0, 32'h0000_0001, "R3 falling edge holds bit");
    wr(0, 32'h0000_0001);
    rd(0, 32'h0, "R5 edge bit cleared");
    setSrc(31, 1'b1);
    wr(0, 32'h0000_0001);
    rd(0, 32'h0, "R3 held-high edge source not re-set");
    // R8 critical routing
    wr(3, 32'h0000_0001);
    rd(3, 32'h0000_0001, "R10 critical routing readback");
    setSrc(31, 1'b0);
    setSrc(31, 1'b1);
    expectOut(2, 1'b1, "R8 critical raised");
    expectOut(1, 1'b0, "R7 normal low for critical source");
    wr(2, 32'h0);
    expectOut(2, 1'b0, "R8 critical masked by enable");
    rd(6, 32'h0, "R9 masked view with enable off");
    rd(0, 32'h0000_0001, "R9 status still latched");
    wr(2, 32'h0000_0001);
    rd(6, 32'h0000_0001, "R9 masked view with enable on");
    wr(6, 32'hFFFF_FFFF);
    rd(0, 32'h0000_0001, "R9 masked write leaves status");
    rd(2, 32'h0000_0001, "R9 masked write leaves enable");
    // R6 set alias
    wr(1, 32'h00F0_0000);
    rd(0, 32'h00F0_0001, "R6 set alias ORs status");
    rd(1, 32'h00F0_0001, "R6 alias reads status");
    expectOut(1, 1'b0, "R7 set bits not enabled");
    wr(2, 32'h00F0_0001);
    expectOut(1, 1'b1, "R7 normal raised by set bits");
    expectOut(2, 1'b1, "R8 critical held");
    // R10 polarity stored only
    wr(4, 32'hA5A5_A5A5);
    rd(4, 32'hA5A5_A5A5, "R10 polarity readback");
    rd(0, 32'h00F0_0001, "R10 polarity no status effect");
    expectOut(1, 1'b1, "R10 polarity no output effect");
    // R11 unmapped
    wr(7, 32'hFFFF_FFFF);
    wr(8, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    wrAbs(10'h000, 32'hFFFF_FFFF);
    rd(7, 32'h0, "R11 vector slot reads zero");
    rd(8, 32'h0, "R11 vector config reads zero");
    rdAbs(10'h000, 32'h0, "R11 outside window reads zero");
    rd(0, 32'h00F0_0001, "R11 unmapped writes leave status");
    rd(2, 32'h00F0_0001, "R11 unmapped writes leave enable");
    rd(3, 32'h0000_0001, "R11 unmapped writes leave routing");
    // R2 mapping of source 5, then full clear
    setSrc(5, 1'b1);
    rd(0, 32'h04F0_0001, "R2 source 5 to bit 26");
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0400_0000, "R5 full clear keeps active level source");
    expectOut(1, 1'b0, "R7 normal drops after clear");
    expectOut(2, 1'b0, "R8 critical drops after clear");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule